// File: doc/BRIEF.md
# Serial-In Latched Blanking Output Register

The block is a cascadable serial-to-parallel output register for driving display anodes or similar banks of outputs. Bits arrive one at a time on a serial data pin and are moved along a chain of register stages on each falling edge of a serial clock. A level-sensitive capture stage copies the chain into a bank of holding bits while its control pin is high and freezes them while it is low. A blanking pin forces every parallel output low without disturbing what is held.

The last stage of the chain leaves the block on a serial output. That pin can be wired to the serial data pin of an identical block so that several blocks form one longer word. All pins are sampled by a fast system clock through two-flop synchronizers, so the whole block is ordinary synchronous logic. The system clock must run at least four times faster than the serial clock, which gives each serial-clock phase at least two samples.

Top module: `serial_latched_driver`

## Requirements
- R1: A synchronous active-high reset clears the shift chain, the holding bits and the outputs, so `par_out` and `ser_dout` read 0 afterwards.
- R2: Each falling edge of `ser_clk` loads `ser_din` into stage 0 (`par_out[0]`, position 1) and moves every stage up by one, so that after 32 falling edges the first bit sent sits at `par_out[31]` (position 32).
- R3: A rising edge of `ser_clk`, or a steady level on it while `ser_din` changes, leaves the shift chain unchanged.
- R4: `ser_dout` carries stage 31 and changes only after a falling edge, so a second block chained to it and clocked by the same `ser_clk` receives the bit held before that edge.
- R5: While `hold_n` is high the holding bits follow the shift chain, including across falling edges that occur while it stays high.
- R6: While `hold_n` is low the holding bits keep their last value whatever is shifted in.
- R7: While `blank` is high all of `par_out` is 0; when `blank` returns low `par_out` again shows the holding bits, which blanking did not alter.
- R8: A serial clock whose high and low phases each last two system clock periods is shifted correctly, one stage per falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all other pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; shifting happens on its falling edge |
| ser_din | input | 1 | Serial data into stage 0 |
| hold_n | input | 1 | High: holding bits follow the chain; low: they hold |
| blank | input | 1 | High forces all parallel outputs low |
| ser_dout | output | 1 | Last stage of the chain, for cascading |
| par_out | output | WIDTH (32) | Parallel outputs, bit 0 is the newest bit |

## Verification
The shift of the chain and the copy into the holding bits can fall in the same system cycle when `hold_n` stays high across a falling edge of `ser_clk`. The bench keeps `hold_n` high through a series of serial edges and, after each one, compares `par_out` with a reference model that first shifts and then copies, so a stale or one-edge-late copy shows up. Blanking is also applied while such shifts run, and the bench checks that the outputs stay zero and that the correct, fully updated word reappears when blanking is released.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Control pins as sampled into the system clock domain.
  typedef struct packed {
    logic sclk;
    logic sdin;
    logic hold;
    logic blank;
  } pins_t;

  localparam int PINS_W = $bits(pins_t);

  // Falling edge seen as previous sample high, current sample low.
  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_st
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[i] <= '0;
          else     st[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= '0;
          else     st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sreg_shift.sv
module sreg_shift
  import sreg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdin_s,
  output logic             shift_now,
  output logic [WIDTH-1:0] chain_q
);
  logic sclk_d;
  logic sdin_d;

  assign shift_now = is_fall(sclk_d, sclk_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      sdin_d  <= 1'b0;
      chain_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      sdin_d <= sdin_s;
      if (shift_now) chain_q <= {chain_q[WIDTH-2:0], sdin_d};
    end
  end

  // R3
  no_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_now |=> $stable(chain_q));

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_now |=> chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0]));
endmodule

// File: rtl/sreg_hold.sv
module sreg_hold #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             follow,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (follow) q <= d;
  end

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !follow |=> $stable(q));

  // R5
  hold_follow_chk: assert property (@(posedge clk) disable iff (rst)
    follow |=> q == $past(d));
endmodule

// File: rtl/sreg_blank.sv
module sreg_blank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blank_s,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (blank_s) q <= '0;
    else              q <= d;
  end

  // R7
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    blank_s |=> q == '0);

  // R7
  blank_show_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_s |=> q == $past(d));
endmodule

// File: rtl/serial_latched_driver.sv
module serial_latched_driver
  import sreg_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             hold_n,
  input  logic             blank,
  output logic             ser_dout,
  output logic [WIDTH-1:0] par_out
);
  pins_t            pins_raw;
  pins_t            pins_s;
  logic             shift_now;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] held_q;

  assign pins_raw = '{sclk: ser_clk, sdin: ser_din, hold: hold_n, blank: blank};

  sreg_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  sreg_shift #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (pins_s.sclk),
    .sdin_s    (pins_s.sdin),
    .shift_now (shift_now),
    .chain_q   (chain_q)
  );

  sreg_hold #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .follow (pins_s.hold),
    .d      (chain_q),
    .q      (held_q)
  );

  sreg_blank #(.WIDTH(WIDTH)) u_blank (
    .clk     (clk),
    .rst     (rst),
    .blank_s (pins_s.blank),
    .d       (held_q),
    .q       (par_out)
  );

  assign ser_dout = chain_q[WIDTH-1];

  // R4
  dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_now |=> $stable(ser_dout));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (par_out == '0) && !ser_dout);
endmodule

// File: tb/tb_serial_latched_driver.sv
module tb_serial_latched_driver;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_clk = 1'b0;
  logic         ser_din = 1'b0;
  logic         hold_n = 1'b0;
  logic         blank = 1'b0;
  logic         dout_a;
  logic         dout_b;
  logic [W-1:0] par_a;
  logic [W-1:0] par_b;

  always #2.5 clk = ~clk;

  serial_latched_driver #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .hold_n(hold_n), .blank(blank), .ser_dout(dout_a), .par_out(par_a));

  serial_latched_driver #(.WIDTH(W)) dut_b (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(dout_a),
    .hold_n(hold_n), .blank(blank), .ser_dout(dout_b), .par_out(par_b));

  typedef struct {
    logic [W-1:0] pa;
    logic         da;
    logic [W-1:0] pb;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  // Reference model state
  logic [W-1:0] m_sr_a = '0;
  logic [W-1:0] m_sr_b = '0;
  logic [W-1:0] m_hd_a = '0;
  logic [W-1:0] m_hd_b = '0;
  logic         m_hold = 1'b0;
  logic         m_blank = 1'b0;

  task automatic model_shift(input logic b);
    logic carry;
    carry  = m_sr_a[W-1];
    m_sr_a = {m_sr_a[W-2:0], b};
    m_sr_b = {m_sr_b[W-2:0], carry};
    if (m_hold) begin
      m_hd_a = m_sr_a;
      m_hd_b = m_sr_b;
    end
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.pa  = m_blank ? '0 : m_hd_a;
    e.pb  = m_blank ? '0 : m_hd_b;
    e.da  = m_sr_a[W-1];
    e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: pops expected items after the pipeline has settled.
  initial begin
    exp_t e;
    forever begin
      wait (sb_q.size() > 0);
      repeat (8) @(negedge clk);
      e = sb_q.pop_front();
      n_run++;
      if (par_a !== e.pa || dout_a !== e.da || par_b !== e.pb) begin
        n_fail++;
        $display("FAIL %s: actual par_a=%h dout=%b par_b=%h expected par_a=%h dout=%b par_b=%h",
                 e.tag, par_a, dout_a, par_b, e.pa, e.da, e.pb);
      end
    end
  end

  task automatic shift_bit(input logic b, input int phase);
    @(negedge clk);
    ser_din = b;
    ser_clk = 1'b1;
    repeat (phase) @(negedge clk);
    ser_clk = 1'b0;
    repeat (phase) @(negedge clk);
    model_shift(b);
  endtask

  task automatic set_hold(input logic v);
    @(negedge clk);
    hold_n = v;
    m_hold = v;
    if (v) begin
      m_hd_a = m_sr_a;
      m_hd_b = m_sr_b;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_blank(input logic v);
    @(negedge clk);
    blank = v;
    m_blank = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic shift_word(input logic [W-1:0] w, input int nbits, input int phase);
    for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i], phase);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    expect_now("R1 reset state");

    // Hold low: shifting must not reach outputs
    shift_word(32'h0000_00A5, 8, 4);
    expect_now("R6 hold low keeps outputs");
    set_hold(1'b1);
    expect_now("R5 hold high copies chain");

    // Blanking
    set_blank(1'b1);
    expect_now("R7 blank forces zero");
    shift_word(32'h0000_003C, 6, 4);
    expect_now("R7 blank while shifting with hold high");
    set_blank(1'b0);
    expect_now("R7 unblank shows updated bits");

    // Full word, ordering
    set_hold(1'b0);
    shift_word(32'hC35A_9E01, 32, 4);
    expect_now("R6 full word shifted while holding");
    set_hold(1'b1);
    expect_now("R2 first bit at position 32");
    if (par_a[31] !== 1'b1 || par_a[0] !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 ordering: actual bit31=%b bit0=%b expected bit31=1 bit0=1",
               par_a[31], par_a[0]);
    end
    n_run++;

    // Rising edge and steady high do not shift
    @(negedge clk);
    ser_din = 1'b0;
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_din = 1'b1;
    repeat (4) @(negedge clk);
    ser_din = 1'b0;
    expect_now("R3 rising edge and high level no shift");
    ser_din = 1'b1;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    model_shift(1'b1);
    expect_now("R3 shift happens only at the fall");

    // Hold high across shifts, checked edge by edge (shift and copy in same cycle)
    for (int i = 0; i < 6; i++) begin
      shift_bit(i[0], 4);
      expect_now("R5 hold high across a shift edge");
    end

    // Chaining: push enough to spill into the second block
    shift_word(32'h1234_5678, 32, 4);
    expect_now("R4 chain after 32 more bits");
    shift_word(32'h0000_F0F0, 16, 4);
    expect_now("R4 chain receives pre-edge bits");

    // Fastest serial clock
    shift_word(32'hBEEF_1357, 32, 2);
    expect_now("R8 two-cycle phases");
    set_hold(1'b0);
    shift_word(32'h0000_00FF, 8, 2);
    expect_now("R8 fast shift with hold low");

    // Reset in the middle of use
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_sr_a = '0; m_sr_b = '0; m_hd_a = '0; m_hd_b = '0;
    expect_now("R1 reset after use");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule